// File: doc/BRIEF.md
# Rotating-Priority Interrupt Request Resolver

This block is the per-controller core of an eight-input interrupt controller. It captures the request lines into a request register. Each line is edge- or level-triggered, as its own trigger-mode bit selects. The block also holds a mask register, an in-service register and a rotating priority offset. From these it works out, combinationally, which line (if any) should be presented to the processor. It also drives a registered interrupt output.

Priority is relative to the offset. The line equal to the offset is the most urgent. The line just below it, modulo eight, is the least urgent. A pending, unmasked request wins only if it is strictly more urgent than the most urgent line already in service. When special fully nested mode is on in a master instance, the in-service bit of the cascade line is left out of that comparison.

The block has no host register interface. A surrounding controller reaches it through a few ports: a mask load, an offset load, set and clear vectors for the in-service bits, and an acknowledge pulse that takes the current winner into service.

Top module: `irq_resolver`

## Requirements
- R1: With its trigger-mode bit at 1 (level), a line's request bit equals the line level sampled at the previous clock edge, so a line that goes low withdraws its request one clock later.
- R2: With its trigger-mode bit at 0 (edge), a request bit is set only when the line is sampled high after being sampled low at the edge before. A falling line does not clear the request bit, and a line held high does not set it again.
- R3: Line l has priority index (l - offset) mod 8, where index 0 is the most urgent. Among pending candidates, the one with the smallest index is reported on win_line_o.
- R4: A line whose mask bit is 1 is never a candidate. mask_we_i loads mask_i at the clock edge.
- R5: win_valid_o is 1 only when the best candidate's priority index is strictly smaller than that of the most urgent in-service line. An empty in-service set counts as index 8.
- R6: In a master instance with fully_nested_i at 1, in-service bit 2 is ignored in the R5 comparison. All other in-service bits still count.
- R7: ack_i together with win_valid_o sets the in-service bit of the winning line at the next edge. For an edge-mode winner it also clears that line's request bit. A level-mode request bit is left untouched.
- R8: irq_o equals win_valid_o delayed by exactly one clock.
- R9: Reset (rst_n low) clears the request, previous-level, mask, in-service and offset registers and irq_o.
- R10: In-service bits are updated at the clock edge. isr_clr_i clears bits and isr_set_i sets bits. When both name the same bit, the set wins.
- R11: ofs_we_i loads ofs_i into the priority offset at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 8 | Interrupt request lines |
| trig_level_i | input | 8 | Per-line trigger mode: 1 level, 0 edge |
| mask_we_i | input | 1 | Load mask_i into the mask register |
| mask_i | input | 8 | New mask value, 1 blocks a line |
| ofs_we_i | input | 1 | Load ofs_i into the priority offset |
| ofs_i | input | 3 | New priority offset (most urgent line) |
| isr_set_i | input | 8 | In-service bits to set |
| isr_clr_i | input | 8 | In-service bits to clear |
| fully_nested_i | input | 1 | Special fully nested mode |
| ack_i | input | 1 | Take the current winner into service |
| win_valid_o | output | 1 | A line should be presented to the processor |
| win_line_o | output | 3 | Number of the winning line |
| irq_o | output | 1 | Registered interrupt output |

## Verification
Errors in the request, in-service or offset state all show up on win_valid_o and win_line_o during the first clock after the state is loaded. A wrong irq_o shows up one clock later. A request bit that fails to clear after an edge-mode acknowledge, or one that clears in level mode, becomes visible as soon as the in-service bit is removed, because the winner then appears or disappears. Random request, mask and in-service patterns are run under every offset value, and the results are compared with a priority model held in the bench.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;
    localparam int LINES = 8;
    localparam int IDX_W = $clog2(LINES);
    localparam int CASCADE_LINE = 2;

    typedef struct packed {
        logic [LINES-1:0] mask;
        logic [LINES-1:0] isr;
        logic [IDX_W-1:0] ofs;
        logic             irq;
    } ctl_state_t;
endpackage

// File: rtl/irq_req_capture.sv
module irq_req_capture #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] line_i,
    input  logic [N-1:0] trig_level_i,
    input  logic [N-1:0] ack_clr_i,
    output logic [N-1:0] req_o
);
    typedef struct packed {
        logic [N-1:0] req;
        logic [N-1:0] prev;
    } cap_state_t;

    cap_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            if (trig_level_i[i]) begin
                st_d.req[i] = line_i[i];
            end else begin
                st_d.req[i] = (st_q.req[i] & ~ack_clr_i[i]) | (line_i[i] & ~st_q.prev[i]);
            end
            st_d.prev[i] = line_i[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_o = st_q.req;

    for (genvar g = 0; g < N; g++) begin : g_chk
        // R1: level request mirrors the line one clock later
        a_r1_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
            trig_level_i[g] |=> (req_o[g] == $past(line_i[g])));
        // R2: no new request without a low-to-high transition
        a_r2_edge_needs_rise: assert property (@(posedge clk) disable iff (!rst_n)
            (!trig_level_i[g] && !req_o[g] && st_q.prev[g]) |=> !req_o[g]);
        // R2: falling line leaves an unacknowledged edge request alone
        a_r2_fall_keeps_req: assert property (@(posedge clk) disable iff (!rst_n)
            (!trig_level_i[g] && req_o[g] && !ack_clr_i[g]) |=> req_o[g]);
    end
endmodule

// File: rtl/irq_prio_find.sv
module irq_prio_find #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec_i,
    input  logic [IW-1:0] ofs_i,
    output logic [IW:0]   prio_o
);
    logic [N-1:0] rot;

    always_comb begin
        for (int p = 0; p < N; p++) begin
            rot[p] = vec_i[IW'(p) + ofs_i];
        end
    end

    always_comb begin
        prio_o = (IW+1)'(N);
        for (int p = N-1; p >= 0; p--) begin
            if (rot[p]) prio_o = (IW+1)'(p);
        end
    end
endmodule

// File: rtl/irq_resolver.sv
module irq_resolver
    import irq_res_pkg::*;
#(
    parameter bit IS_MASTER = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] line_i,
    input  logic [LINES-1:0] trig_level_i,
    input  logic             mask_we_i,
    input  logic [LINES-1:0] mask_i,
    input  logic             ofs_we_i,
    input  logic [IDX_W-1:0] ofs_i,
    input  logic [LINES-1:0] isr_set_i,
    input  logic [LINES-1:0] isr_clr_i,
    input  logic             fully_nested_i,
    input  logic             ack_i,
    output logic             win_valid_o,
    output logic [IDX_W-1:0] win_line_o,
    output logic             irq_o
);
    ctl_state_t       st_d, st_q;
    logic [LINES-1:0] req_w;
    logic [LINES-1:0] cand_w;
    logic [LINES-1:0] isr_eff_w;
    logic [LINES-1:0] ack_vec_w;
    logic [IDX_W:0]   cand_prio_w;
    logic [IDX_W:0]   isr_prio_w;

    irq_req_capture #(.N(LINES)) u_cap (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_i       (line_i),
        .trig_level_i (trig_level_i),
        .ack_clr_i    (ack_vec_w),
        .req_o        (req_w)
    );

    assign cand_w = req_w & ~st_q.mask;

    if (IS_MASTER) begin : g_master
        always_comb begin
            isr_eff_w = st_q.isr;
            if (fully_nested_i) isr_eff_w[CASCADE_LINE] = 1'b0;
        end
    end else begin : g_slave
        assign isr_eff_w = st_q.isr;
    end

    irq_prio_find #(.N(LINES), .IW(IDX_W)) u_cand (
        .vec_i  (cand_w),
        .ofs_i  (st_q.ofs),
        .prio_o (cand_prio_w)
    );

    irq_prio_find #(.N(LINES), .IW(IDX_W)) u_isr (
        .vec_i  (isr_eff_w),
        .ofs_i  (st_q.ofs),
        .prio_o (isr_prio_w)
    );

    assign win_valid_o = cand_prio_w < isr_prio_w;
    assign win_line_o  = cand_prio_w[IDX_W-1:0] + st_q.ofs;
    assign ack_vec_w   = (ack_i && win_valid_o) ? (LINES'(1) << win_line_o) : '0;

    always_comb begin
        st_d      = st_q;
        st_d.isr  = (st_q.isr & ~isr_clr_i) | isr_set_i | ack_vec_w;
        if (mask_we_i) st_d.mask = mask_i;
        if (ofs_we_i)  st_d.ofs  = ofs_i;
        st_d.irq  = win_valid_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.irq;

    // R4: the winner is a pending line that is not masked
    a_r4_winner_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid_o |-> (req_w[win_line_o] && !st_q.mask[win_line_o]));
    // R5: a line already in service (and counted) can never win
    a_r5_not_in_service: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid_o |-> !isr_eff_w[win_line_o]);
    // R7: acknowledge puts the winner in service
    a_r7_ack_sets_isr: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && win_valid_o) |=> st_q.isr[$past(win_line_o)]);
    // R8: interrupt output trails the winner flag by one clock
    a_r8_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid_o |=> irq_o);
    a_r8_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !win_valid_o |=> !irq_o);
endmodule

// File: tb/irq_resolver_test.sv
`timescale 1ns/1ps
module irq_resolver_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] line_i = '0, trig_level_i = 8'hFF, mask_i = '0, isr_set_i = '0, isr_clr_i = '0;
    logic       mask_we_i = 0, ofs_we_i = 0, fully_nested_i = 0, ack_i = 0;
    logic [2:0] ofs_i = '0;
    logic       win_valid_o, irq_o;
    logic [2:0] win_line_o;
    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    irq_resolver uut (.*);

    // rows: req, mask, isr, ofs, {expected valid, expected line}
    localparam logic [39:0] VEC [12] = '{
        40'h00_00_00_00_00, 40'h81_00_00_00_10, 40'h81_00_00_01_17,
        40'h81_80_00_01_10, 40'h10_00_04_00_00, 40'h02_00_04_00_11,
        40'h04_00_04_00_00, 40'h10_00_04_03_14, 40'hFF_FF_00_00_00,
        40'h60_00_00_06_16, 40'h60_00_00_07_15, 40'h08_00_80_00_13
    };

    task automatic chk(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load(logic [7:0] rq, logic [7:0] mk, logic [7:0] is, logic [2:0] of, logic sf);
        trig_level_i = 8'hFF; line_i = rq;
        mask_we_i = 1; mask_i = mk; ofs_we_i = 1; ofs_i = of;
        isr_clr_i = 8'hFF; isr_set_i = is; fully_nested_i = sf;
        tick();
        mask_we_i = 0; ofs_we_i = 0; isr_clr_i = 0; isr_set_i = 0;
    endtask

    function automatic logic [3:0] model(logic [7:0] rq, logic [7:0] mk, logic [7:0] is,
                                         logic [2:0] of, logic sf);
        int cp = 8, ip = 8;
        logic [7:0] c = rq & ~mk;
        logic [7:0] s = is;
        if (sf) s[2] = 1'b0;
        for (int l = 0; l < 8; l++) begin
            int p = (l - of + 8) % 8;
            if (c[l] && p < cp) cp = p;
            if (s[l] && p < ip) ip = p;
        end
        if (cp < ip) return {1'b1, 3'((cp + of) % 8)};
        return 4'b0000;
    endfunction

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        // R9: reset state, with a level line held high during reset
        line_i = 8'h01;
        @(negedge clk);
        chk("R9 valid in reset", win_valid_o, 0);
        chk("R9 irq in reset", irq_o, 0);
        line_i = 0;
        rst_n = 1;
        tick();
        chk("R9 valid after reset", win_valid_o, 0);
        chk("R9 irq after reset", irq_o, 0);

        // R3 R4 R5 R11: table of patterns
        for (int k = 0; k < 12; k++) begin
            automatic logic [39:0] v = VEC[k];
            load(v[39:32], v[31:24], v[23:16], v[10:8], 1'b0);
            chk("R3/R5 table valid", win_valid_o, int'(v[4]));
            if (v[4]) chk("R3/R4 table line", win_line_o, int'(v[2:0]));
        end

        // R3 R11: every offset against the model
        for (int of = 0; of < 8; of++) begin
            for (int n = 0; n < 30; n++) begin
                automatic logic [7:0] rq = 8'($urandom);
                automatic logic [7:0] mk = 8'($urandom) & 8'($urandom);
                automatic logic [7:0] is = 8'($urandom) & 8'($urandom) & 8'($urandom);
                automatic logic       sf = 1'($urandom);
                automatic logic [3:0] e = model(rq, mk, is, 3'(of), sf);
                load(rq, mk, is, 3'(of), sf);
                chk("R3 model valid", win_valid_o, int'(e[3]));
                if (e[3]) chk("R3 model line", win_line_o, int'(e[2:0]));
            end
        end

        // R1: level line withdraws its request
        load(8'h04, 0, 0, 0, 0);
        chk("R1 level pending", win_valid_o, 1);
        line_i = 0; tick();
        chk("R1 level withdrawn", win_valid_o, 0);

        // R2: edge capture
        load(0, 0, 0, 0, 0);
        trig_level_i = 8'h00; tick();
        line_i = 8'h01; tick();
        chk("R2 rising sets", win_valid_o, 1);
        line_i = 0; tick();
        chk("R2 falling keeps", win_valid_o, 1);
        line_i = 8'h01; tick();
        ack_i = 1; tick(); ack_i = 0;
        chk("R7 edge in service", win_valid_o, 0);
        isr_clr_i = 8'h01; tick(); isr_clr_i = 0;
        chk("R7/R2 edge request cleared, held line no retrigger", win_valid_o, 0);

        // R7: level request survives acknowledge
        load(8'h08, 0, 0, 0, 0);
        ack_i = 1; tick(); ack_i = 0;
        chk("R7 level in service blocks", win_valid_o, 0);
        isr_clr_i = 8'h08; tick(); isr_clr_i = 0;
        chk("R7 level request kept", win_valid_o, 1);
        chk("R7 level line", win_line_o, 3);

        // R8: interrupt output delay
        load(0, 0, 0, 0, 0); tick();
        chk("R8 irq idle", irq_o, 0);
        line_i = 8'h20; tick();
        chk("R8 winner now", win_valid_o, 1);
        chk("R8 irq not yet", irq_o, 0);
        tick();
        chk("R8 irq one clock later", irq_o, 1);
        line_i = 0; tick();
        chk("R8 irq still high", irq_o, 1);
        tick();
        chk("R8 irq drops", irq_o, 0);

        // R6: special fully nested mode
        load(8'h10, 0, 8'h04, 0, 1);
        chk("R6 cascade ignored", win_valid_o, 1);
        chk("R6 line", win_line_o, 4);
        load(8'h10, 0, 8'h04, 0, 0);
        chk("R6 off blocks", win_valid_o, 0);
        load(8'h10, 0, 8'h02, 0, 1);
        chk("R6 other bits count", win_valid_o, 0);

        // R10: set wins over clear
        load(8'h80, 0, 0, 0, 0);
        isr_clr_i = 8'h40; isr_set_i = 8'h40; tick();
        isr_clr_i = 0; isr_set_i = 0;
        chk("R10 set wins", win_valid_o, 0);
        isr_clr_i = 8'h40; tick(); isr_clr_i = 0;
        chk("R10 clear", win_valid_o, 1);
        chk("R10 line", win_line_o, 7);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule